// File: doc/BRIEF.md
# ATA PIO Sector Transfer Sequencer

This block is the host side of a programmed-I/O disk transfer. A caller hands it one request: a 28-bit logical block address, an 8-bit sector count, a direction flag and a choice of primary or secondary drive. The sequencer first makes sure the drive is idle and ready. It then fills the task-file registers, issues the read or write command and moves each 512-byte sector as 256 word accesses on a simple register bus. Each sector is gated by a status handshake, and the drive must report a clean final state at the end.

Data words pass between the bus and a local word FIFO. The two bytes of every word are exchanged in both directions. Every wait on the drive's busy flag is bounded by a cycle counter, and an expired wait ends the request with an error. The request finishes with a one-cycle done or error pulse.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `bus_cs` are low. The block never raises `bus_rd` and `bus_wr` in the same cycle.
- R2: On `start`, the block reads the alternate status at `bus_addr` 4'hE each cycle while bit 7 (busy) is set. Once bit 7 is clear, bit 6 (ready) must be set, or the request fails without any task-file write.
- R3: The task file is written with the data in the low byte of `bus_wdata`, in this order: count at address 2, LBA[7:0] at 3, LBA[15:8] at 4, LBA[23:16] at 5, then the select register at 6. The select register holds 0x40 OR the device bit 0x10 (when `dev_sel`=1) OR LBA[27:24]. The select write comes in the cycle just before the command write.
- R4: The command is written at address 7: 0x20 when `dir_write`=0 (read) and 0x30 when `dir_write`=1 (write).
- R5: Before each sector, the alternate status is polled until bit 7 clears. Bit 3 (data request) must then be set, or the request fails with no data access.
- R6: Each sector takes exactly 256 accesses at address 0. A read word `{a,b}` is pushed to the FIFO as `{b,a}`, and a FIFO word `{a,b}` is written to the bus as `{b,a}`. Accesses wait while `rx_full` (read) or `tx_empty` (write) is high.
- R7: After the last word of each sector, the status register at address 7 is read once.
- R8: After the final sector, bit 7 must clear, and then bit 6 must be set with bit 3 clear, or the request fails.
- R9: If the busy flag is seen on TIMEOUT_CYC consecutive polls, the request fails. If the flag clears on the last allowed poll, this is not a timeout.
- R10: A sector count of 0 is written to the drive as 0. No data is moved, and the final status check follows the command directly.
- R11: `done` and `error` are single-cycle pulses that never occur together, and `busy` is low in the cycle after either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken while idle |
| dir_write | input | 1 | 1 = write sectors, 0 = read sectors |
| dev_sel | input | 1 | 1 = secondary drive |
| lba | input | 28 | Starting logical block address |
| sec_count | input | 8 | Number of sectors |
| busy | output | 1 | Request in progress |
| done | output | 1 | Success pulse |
| error | output | 1 | Failure pulse |
| bus_cs | output | 1 | Register bus select |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | 4 | Register address (bit 3 selects the control block) |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid in the strobe cycle |
| rx_push | output | 1 | Push a read word into the local FIFO |
| rx_data | output | 16 | Byte-swapped read word |
| rx_full | input | 1 | Local FIFO cannot accept a word |
| tx_pop | output | 1 | Take a word from the local FIFO |
| tx_data | input | 16 | Word to be written |
| tx_empty | input | 1 | Local FIFO has no word |

## Verification
A busy poll can both drop the busy flag and be the poll on which the timeout counter reaches its limit. In that case the status judgement must win over the timeout. The bench provokes this by having the drive model hold busy for exactly TIMEOUT_CYC-1 polls, which must end in done, and for exactly TIMEOUT_CYC polls, which must end in error with no task-file write. The other overlap is the last word of a sector together with a stalled FIFO. Here the bench throttles the FIFO flags while the scoreboard checks every word and the single status read after each sector.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam logic [3:0] RA_DATA  = 4'h0;
  localparam logic [3:0] RA_COUNT = 4'h2;
  localparam logic [3:0] RA_SECT  = 4'h3;
  localparam logic [3:0] RA_CYLLO = 4'h4;
  localparam logic [3:0] RA_CYLHI = 4'h5;
  localparam logic [3:0] RA_DEVHD = 4'h6;
  localparam logic [3:0] RA_CMDST = 4'h7;
  localparam logic [3:0] RA_ALTST = 4'hE;

  localparam int unsigned ST_BSY = 7;
  localparam int unsigned ST_RDY = 6;
  localparam int unsigned ST_DRQ = 3;

  localparam logic [7:0] OP_RD_SECT = 8'h20;
  localparam logic [7:0] OP_WR_SECT = 8'h30;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK_RDY, S_TF_CNT, S_TF_SEC, S_TF_CLO, S_TF_CHI, S_TF_DEV,
    S_TF_CMD, S_CHK_DRQ, S_XFER, S_ACK, S_CHK_END, S_DONE, S_FAIL
  } seq_state_t;

  typedef enum logic [1:0] {CHK_NONE, CHK_READY, CHK_DATA, CHK_FINAL} chk_kind_t;

  function automatic logic [15:0] swap16(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  function automatic logic [7:0] lba_slice(input logic [27:0] a, input logic [1:0] idx);
    case (idx)
      2'd0:    return a[7:0];
      2'd1:    return a[15:8];
      2'd2:    return a[23:16];
      default: return {4'h0, a[27:24]};
    endcase
  endfunction

  function automatic logic [7:0] devhead(input logic [27:0] a, input logic dev);
    return {1'b0, 1'b1, 1'b0, dev, a[27:24]};
  endfunction
endpackage

// File: rtl/ata_wait_timer.sv
module ata_wait_timer #(
  parameter int unsigned LIMIT = 500000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bsy_poll,
  output logic expired
);
  localparam int unsigned TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (bsy_poll) cnt <= cnt + 1'b1;
    else               cnt <= '0;
  end

  assign expired = bsy_poll && (cnt == LAST);
endmodule

// File: rtl/ata_status_judge.sv
module ata_status_judge
  import ata_pio_pkg::*;
(
  input  chk_kind_t  kind,
  input  logic [7:0] st,
  output logic       bsy,
  output logic       ok
);
  always_comb begin
    bsy = st[ST_BSY];
    case (kind)
      CHK_READY: ok = st[ST_RDY];
      CHK_DATA:  ok = st[ST_DRQ];
      CHK_FINAL: ok = st[ST_RDY] && !st[ST_DRQ];
      default:   ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/ata_xfer_counter.sv
module ata_xfer_counter #(
  parameter int unsigned WORDS = 256,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_count,
  input  logic             step,
  output logic             sector_end,
  output logic             no_sectors
);
  localparam int unsigned WW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [WW-1:0] LAST_WORD = WW'(WORDS - 1);

  logic [WW-1:0]    words;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words <= '0;
      left  <= '0;
    end else if (load) begin
      words <= '0;
      left  <= load_count;
    end else if (step) begin
      if (sector_end) begin
        words <= '0;
        left  <= left - 1'b1;
      end else begin
        words <= words + 1'b1;
      end
    end
  end

  assign sector_end = step && (words == LAST_WORD);
  assign no_sectors = (left == '0);
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC      = 500000000,
  parameter int unsigned WORDS_PER_SECTOR = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        dir_write,
  input  logic        dev_sel,
  input  logic [27:0] lba,
  input  logic [7:0]  sec_count,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic        bus_cs,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [3:0]  bus_addr,
  output logic [15:0] bus_wdata,
  input  logic [15:0] bus_rdata,
  output logic        rx_push,
  output logic [15:0] rx_data,
  input  logic        rx_full,
  output logic        tx_pop,
  input  logic [15:0] tx_data,
  input  logic        tx_empty
);
  seq_state_t  state, nxt;
  logic [27:0] lba_q;
  logic [7:0]  cnt_q;
  logic        wr_q;
  logic        dev_q;

  chk_kind_t kind;
  logic      st_bsy, st_ok;
  logic      bsy_poll, tmo_hit;
  logic      step, sector_end, no_sectors;
  logic      take_req;

  assign take_req = (state == S_IDLE) && start;

  always_comb begin
    case (state)
      S_CHK_RDY: kind = CHK_READY;
      S_CHK_DRQ: kind = CHK_DATA;
      S_CHK_END: kind = CHK_FINAL;
      default:   kind = CHK_NONE;
    endcase
  end

  ata_status_judge u_judge (
    .kind (kind),
    .st   (bus_rdata[7:0]),
    .bsy  (st_bsy),
    .ok   (st_ok)
  );

  assign bsy_poll = (kind != CHK_NONE) && st_bsy;

  ata_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bsy_poll (bsy_poll),
    .expired  (tmo_hit)
  );

  assign step = (state == S_XFER) && (wr_q ? !tx_empty : !rx_full);

  ata_xfer_counter #(.WORDS(WORDS_PER_SECTOR), .CNT_W(8)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (take_req),
    .load_count (sec_count),
    .step       (step),
    .sector_end (sector_end),
    .no_sectors (no_sectors)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      lba_q <= '0;
      cnt_q <= '0;
      wr_q  <= 1'b0;
      dev_q <= 1'b0;
    end else begin
      state <= nxt;
      if (take_req) begin
        lba_q <= lba;
        cnt_q <= sec_count;
        wr_q  <= dir_write;
        dev_q <= dev_sel;
      end
    end
  end

  // status wait: busy keeps polling unless the limit is hit; a clear flag is judged
  function automatic seq_state_t after_poll(input logic b, input logic ok_v,
                                            input logic tmo, input seq_state_t pass);
    if (b) return tmo ? S_FAIL : state;
    return ok_v ? pass : S_FAIL;
  endfunction

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:    if (start) nxt = S_CHK_RDY;
      S_CHK_RDY: nxt = after_poll(st_bsy, st_ok, tmo_hit, S_TF_CNT);
      S_TF_CNT:  nxt = S_TF_SEC;
      S_TF_SEC:  nxt = S_TF_CLO;
      S_TF_CLO:  nxt = S_TF_CHI;
      S_TF_CHI:  nxt = S_TF_DEV;
      S_TF_DEV:  nxt = S_TF_CMD;
      S_TF_CMD:  nxt = no_sectors ? S_CHK_END : S_CHK_DRQ;
      S_CHK_DRQ: nxt = after_poll(st_bsy, st_ok, tmo_hit, S_XFER);
      S_XFER:    if (sector_end) nxt = S_ACK;
      S_ACK:     nxt = no_sectors ? S_CHK_END : S_CHK_DRQ;
      S_CHK_END: nxt = after_poll(st_bsy, st_ok, tmo_hit, S_DONE);
      S_DONE:    nxt = S_IDLE;
      S_FAIL:    nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_comb begin
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = RA_DATA;
    bus_wdata = '0;
    rx_push   = 1'b0;
    tx_pop    = 1'b0;
    case (state)
      S_CHK_RDY, S_CHK_DRQ, S_CHK_END: begin
        bus_rd   = 1'b1;
        bus_addr = RA_ALTST;
      end
      S_TF_CNT: begin
        bus_wr    = 1'b1;
        bus_addr  = RA_COUNT;
        bus_wdata = {8'h00, cnt_q};
      end
      S_TF_SEC: begin
        bus_wr    = 1'b1;
        bus_addr  = RA_SECT;
        bus_wdata = {8'h00, lba_slice(lba_q, 2'd0)};
      end
      S_TF_CLO: begin
        bus_wr    = 1'b1;
        bus_addr  = RA_CYLLO;
        bus_wdata = {8'h00, lba_slice(lba_q, 2'd1)};
      end
      S_TF_CHI: begin
        bus_wr    = 1'b1;
        bus_addr  = RA_CYLHI;
        bus_wdata = {8'h00, lba_slice(lba_q, 2'd2)};
      end
      S_TF_DEV: begin
        bus_wr    = 1'b1;
        bus_addr  = RA_DEVHD;
        bus_wdata = {8'h00, devhead(lba_q, dev_q)};
      end
      S_TF_CMD: begin
        bus_wr    = 1'b1;
        bus_addr  = RA_CMDST;
        bus_wdata = {8'h00, (wr_q ? OP_WR_SECT : OP_RD_SECT)};
      end
      S_XFER: begin
        bus_addr = RA_DATA;
        if (wr_q) begin
          bus_wr    = !tx_empty;
          tx_pop    = !tx_empty;
          bus_wdata = swap16(tx_data);
        end else begin
          bus_rd  = !rx_full;
          rx_push = !rx_full;
        end
      end
      S_ACK: begin
        bus_rd   = 1'b1;
        bus_addr = RA_CMDST;
      end
      default: ;
    endcase
  end

  assign bus_cs  = bus_rd || bus_wr;
  assign rx_data = swap16(bus_rdata);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_DONE);
  assign error   = (state == S_FAIL);
endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [3:0] bus_addr,
  input logic       sector_end,
  input logic       tmo_hit
);
  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_sel_before_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'h7) |-> $past(bus_wr && bus_addr == 4'h6));

  assert_ack_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sector_end |=> (bus_rd && bus_addr == 4'h7));

  assert_timeout_fails_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (error && !done));

  assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |=> (!done && !error && !busy));
endmodule

bind ata_pio_seq ata_pio_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .error      (error),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .sector_end (sector_end),
  .tmo_hit    (tmo_hit)
);

// File: tb/ata_pio_seq_tb.sv
module ata_pio_seq_tb;
  localparam int TO = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0, dir_write = 0, dev_sel = 0;
  logic [27:0] lba = '0;
  logic [7:0]  sec_count = '0;
  logic busy, done, error, bus_cs, bus_rd, bus_wr, rx_push, tx_pop;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata, rx_data, tx_data;
  logic rx_full, tx_empty;

  always #4 clk = ~clk;

  ata_pio_seq #(.TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write), .dev_sel(dev_sel),
    .lba(lba), .sec_count(sec_count), .busy(busy), .done(done), .error(error),
    .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_push(rx_push), .rx_data(rx_data),
    .rx_full(rx_full), .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty)
  );

  // drive model configuration (set by the stimulus only)
  int   cfg_pre_bsy = 3, cfg_sec_bsy = 2;
  logic cfg_rdy = 1, cfg_bad_drq = 0, cfg_end_drq = 0, stall_en = 0;

  // drive model state (updated by the model only)
  int   bsy_left, remaining, cur_sec, didx, tf_writes, stat_reads, data_acc, tx_idx, cyc;
  logic drq;
  logic [7:0] tf [0:7];
  logic [7:0] st;

  function automatic logic [15:0] pat(input int s, input int w);
    return {8'(s) ^ 8'hA5, 8'(w)};
  endfunction
  function automatic logic [15:0] txw(input int i);
    return 16'(i * 263 + 16'h1234);
  endfunction
  function automatic logic [15:0] bswap(input logic [15:0] w);
    return 16'((w << 8) | (w >> 8));
  endfunction

  always_comb begin
    st = {bsy_left > 0, cfg_rdy, 2'b00, (bsy_left == 0) && drq, 3'b000};
    case (bus_addr)
      4'h0:       bus_rdata = pat(cur_sec, didx);
      4'h7, 4'hE: bus_rdata = {8'h00, st};
      default:    bus_rdata = {8'h00, tf[bus_addr[2:0]]};
    endcase
  end
  assign rx_full  = stall_en && (cyc % 3 == 0);
  assign tx_empty = stall_en && (cyc % 4 == 1);
  assign tx_data  = txw(tx_idx);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (start) begin
      bsy_left <= cfg_pre_bsy; drq <= 0; tf_writes <= 0; stat_reads <= 0;
      data_acc <= 0; tx_idx <= 0; cur_sec <= 0; didx <= 0; remaining <= 0;
    end else begin
      if (bus_rd && bus_addr == 4'hE && bsy_left > 0) bsy_left <= bsy_left - 1;
      if (bus_rd && bus_addr == 4'h7) stat_reads <= stat_reads + 1;
      if (bus_wr && bus_addr != 4'h0 && !bus_addr[3]) begin
        tf[bus_addr[2:0]] <= bus_wdata[7:0];
        tf_writes <= tf_writes + 1;
        if (bus_addr == 4'h7) begin
          remaining <= int'(tf[2]);
          bsy_left  <= cfg_sec_bsy;
          drq       <= (tf[2] != 0) && !cfg_bad_drq;
        end
      end
      if ((bus_rd || bus_wr) && bus_addr == 4'h0) begin
        data_acc <= data_acc + 1;
        if (bus_wr) tx_idx <= tx_idx + 1;
        if (didx == 255) begin
          didx <= 0; cur_sec <= cur_sec + 1; remaining <= remaining - 1;
          bsy_left <= cfg_sec_bsy;
          drq <= (remaining > 1) ? 1'b1 : cfg_end_drq;
        end else didx <= didx + 1;
      end
    end
  end

  // scoreboard
  logic [15:0] exp_q[$];
  int sb_cmp = 0, sb_bad = 0;
  task automatic sb_take(input logic [15:0] got);
    logic [15:0] e;
    sb_cmp++;
    if (exp_q.size() == 0) begin
      sb_bad++;
      $display("FAIL R6: unexpected data word actual %h expected none", got);
    end else begin
      e = exp_q.pop_front();
      if (got !== e) begin
        sb_bad++;
        $display("FAIL R6: data word actual %h expected %h", got, e);
      end
    end
  endtask
  always @(negedge clk) if (rst_n) begin
    if (rx_push) sb_take(rx_data);
    if (bus_wr && bus_addr == 4'h0) sb_take(bus_wdata);
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit c, input string req, input int act, input int exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic got_done, got_err;
  task automatic run(input logic [27:0] a, input int n, input logic w, input logic d);
    int k;
    @(negedge clk);
    lba = a; sec_count = 8'(n); dir_write = w; dev_sel = d; start = 1;
    @(negedge clk);
    start = 0;
    got_done = 0; got_err = 0;
    for (k = 0; k < 20000; k++) begin
      if (done || error) break;
      @(negedge clk);
    end
    got_done = done; got_err = error;
    if (k == 20000) chk(0, "R11 watchdog", 0, 1);
    @(negedge clk);
    chk(!done && !error && !busy, "R11 single pulse", {done, error, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + sb_cmp + 1, n_fail + sb_bad + 1);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(!busy && !done && !error && !bus_cs, "R1 reset outputs", {busy, done, error, bus_cs}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !bus_cs, "R1 idle after reset", {busy, bus_cs}, 0);

    // two-sector read, primary drive
    for (int s = 0; s < 2; s++) for (int i = 0; i < 256; i++) exp_q.push_back(bswap(pat(s, i)));
    run(28'hABCDEF1, 2, 0, 0);
    chk(got_done && !got_err, "R11 read done", got_done, 1);
    chk(tf[2] == 8'h02, "R3 count reg", tf[2], 2);
    chk(tf[3] == 8'hF1 && tf[4] == 8'hDE && tf[5] == 8'hBC, "R3 lba bytes",
        {tf[5], tf[4], tf[3]}, 24'hBCDEF1);
    chk(tf[6] == 8'h4A, "R3 select primary", tf[6], 8'h4A);
    chk(tf[7] == 8'h20, "R4 read command", tf[7], 8'h20);
    chk(stat_reads == 2, "R7 status reads", stat_reads, 2);
    chk(data_acc == 512, "R6 read accesses", data_acc, 512);
    chk(exp_q.size() == 0, "R6 read words left", exp_q.size(), 0);

    // one-sector write, secondary drive, throttled FIFO
    stall_en = 1;
    for (int i = 0; i < 256; i++) exp_q.push_back(bswap(txw(i)));
    run(28'h0123456, 1, 1, 1);
    chk(got_done, "R11 write done", got_done, 1);
    chk(tf[6] == 8'h50, "R3 select secondary", tf[6], 8'h50);
    chk(tf[7] == 8'h30, "R4 write command", tf[7], 8'h30);
    chk(data_acc == 256, "R6 write accesses", data_acc, 256);
    chk(exp_q.size() == 0, "R6 write words left", exp_q.size(), 0);
    chk(stat_reads == 1, "R7 status read after write", stat_reads, 1);

    // drive not ready
    cfg_rdy = 0;
    run(28'h10, 1, 0, 0);
    chk(got_err, "R2 not ready fails", got_err, 1);
    chk(tf_writes == 0, "R2 no task file write", tf_writes, 0);
    cfg_rdy = 1;

    // no data request after command
    cfg_bad_drq = 1;
    run(28'h20, 1, 0, 0);
    chk(got_err, "R5 missing DRQ fails", got_err, 1);
    chk(data_acc == 0, "R5 no data access", data_acc, 0);
    cfg_bad_drq = 0;

    // DRQ still set after last sector, with read stalls
    cfg_end_drq = 1;
    for (int i = 0; i < 256; i++) exp_q.push_back(bswap(pat(0, i)));
    run(28'h30, 1, 0, 0);
    chk(got_err && !got_done, "R8 end check fails", got_err, 1);
    chk(exp_q.size() == 0, "R6 stalled read words", exp_q.size(), 0);
    cfg_end_drq = 0; stall_en = 0;

    // timeout boundary
    cfg_pre_bsy = TO;
    run(28'h40, 1, 0, 0);
    chk(got_err, "R9 timeout fails", got_err, 1);
    chk(tf_writes == 0, "R9 no write after timeout", tf_writes, 0);
    cfg_pre_bsy = TO - 1;
    run(28'h40, 0, 0, 0);
    chk(got_done, "R9 clear on last poll", got_done, 1);
    cfg_pre_bsy = 3;

    // zero sector count
    run(28'h50, 0, 0, 1);
    chk(got_done, "R10 zero count done", got_done, 1);
    chk(tf[2] == 8'h00, "R10 count written zero", tf[2], 0);
    chk(data_acc == 0 && stat_reads == 0, "R10 no data", data_acc, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + sb_cmp, n_fail + sb_bad);
    $finish;
  end
endmodule